// File: doc/BRIEF.md
# Supervisory Reset Pulse Stretcher

This block generates the system reset for a clocked domain. Three conditions call for reset: a supply-good flag from an external voltage comparator that reads low, an active-low manual reset line that is pulled low, and an active-low reset request that is typically wired from a watchdog's timeout output. Each input comes from outside the clock domain, so it first passes through a synchronizer. While any of the three is active, reset is held asserted.

Once every source has gone quiet, the block keeps reset asserted for a fixed number of clock cycles, `HOLD_CYCLES`, and then releases it. This hold applies in every case: at power-up, after a manual press, after a watchdog request, and after a brief supply dip. A pulse that lasts only one cycle therefore still produces a full-length reset. Because of the hold, contact bounce on the manual line needs no separate debounce logic. Whenever a source becomes active again, the hold count is cleared, and counting starts over only after all sources are quiet. A parameter sets the polarity of the reset output. A status output shows when the hold count is running.

Top module: `rst_supervisor`

## Requirements
- R1: While any source is active (`supply_ok_i`=0, `man_rst_ni`=0 or `wdog_req_ni`=0), reset is asserted. An input change reaches the reset state after SYNC_STAGES+1 rising clock edges.
- R2: At power-up, reset stays asserted after `rst_ni` releases. When all sources are inactive, it deasserts exactly HOLD_CYCLES edges after the synchronized sources are first seen inactive.
- R3: Each reset assertion lasts at least HOLD_CYCLES cycles. A source active for a single clock cycle yields an assertion of exactly HOLD_CYCLES cycles.
- R4: A supply dip during the hold clears the hold count. Counting restarts from zero only after supply-good returns, so release moves out by a full HOLD_CYCLES.
- R5: Reset stays asserted for the whole time `man_rst_ni` is low, and for HOLD_CYCLES cycles after its synchronized release.
- R6: With ACTIVE_HIGH=0, `sys_rst_o` is 0 when reset is asserted. With ACTIVE_HIGH=1, it is 1 when reset is asserted.
- R7: A low on `wdog_req_ni` acts exactly like a low on the manual reset line.
- R8: `hold_busy_o` is 1 exactly when reset is asserted and every synchronized source is inactive, that is, while the hold count runs.
- R9: A low on `rst_ni` asserts reset at once, without waiting for a clock edge. It clears the hold count and sets every synchronizer stage to its active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on clear, active low |
| supply_ok_i | input | 1 | Supply-good flag from the comparator (asynchronous) |
| man_rst_ni | input | 1 | Manual reset line, active low (asynchronous) |
| wdog_req_ni | input | 1 | Reset request from the watchdog, active low (asynchronous) |
| sys_rst_o | output | 1 | System reset, polarity set by ACTIVE_HIGH |
| hold_busy_o | output | 1 | High while the hold count is running |

## Verification
The hardest case to reach is a supply dip that lands partway through a hold which was started by another source. This case is the only way to tell "clear the count and restart" apart from "pause the count and resume". The stimulus releases the manual line, waits about half the hold period, and drops supply-good for a single cycle. A cycle-accurate reference model then requires the release to come a full HOLD_CYCLES after the synchronized dip ends. A one-cycle manual pulse is also measured for its exact width, and the power-on clear is pulled low between clock edges to show that assertion does not wait for a clock.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  typedef enum int {
    SRC_SUPPLY = 0,
    SRC_MANUAL = 1,
    SRC_WDOG   = 2
  } src_e;

  localparam int NUM_SRC = 3;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rst_sup_sync.sv
module rst_sup_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= RST_VAL;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

  if (STAGES > 1) begin : g_chk
    assert_sync_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_o == $past(stage_q[STAGES-2]));
  end
endmodule

// File: rtl/rst_sup_hold_timer.sv
module rst_sup_hold_timer
  import rst_sup_pkg::*;
#(
  parameter int HOLD_CYCLES = 10_000_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_active_i,
  output logic               asserted_o,
  output logic               busy_o
);
  localparam int CNT_W = cnt_width(HOLD_CYCLES);
  localparam int LEN_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(HOLD_CYCLES);

  logic             any_act;
  logic             rst_q;
  logic [CNT_W-1:0] cnt_q;

  assign any_act = |src_active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (any_act) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (rst_q) begin
      if (cnt_q == LAST) begin
        rst_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign asserted_o = rst_q;
  assign busy_o     = rst_q & ~any_act;

  // assertion-only: length of current assertion, saturating
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               len_q <= '0;
    else if (!rst_q)           len_q <= '0;
    else if (len_q != '1)      len_q <= len_q + LEN_W'(1);
  end

  assert_src_forces_rst_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_act |=> rst_q);

  assert_supply_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_active_i[int'(SRC_SUPPLY)] |=> (cnt_q == '0));

  assert_min_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> (len_q >= MIN_LEN));

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (cnt_q == '0));
endmodule

// File: rtl/rst_sup_pol.sv
module rst_sup_pol #(
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic asserted_i,
  output logic rst_o
);
  if (ACTIVE_HIGH) begin : g_hi
    assign rst_o = asserted_i;
  end else begin : g_lo
    assign rst_o = ~asserted_i;
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int HOLD_CYCLES = 10_000_000,
  parameter int SYNC_STAGES = 2,
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic man_rst_ni,
  input  logic wdog_req_ni,
  output logic sys_rst_o,
  output logic hold_busy_o
);
  logic [NUM_SRC-1:0] raw_act;
  logic [NUM_SRC-1:0] sync_act;
  logic               asserted;

  // all sources mapped to active-high before synchronizing
  always_comb begin
    raw_act                   = '0;
    raw_act[int'(SRC_SUPPLY)] = ~supply_ok_i;
    raw_act[int'(SRC_MANUAL)] = ~man_rst_ni;
    raw_act[int'(SRC_WDOG)]   = ~wdog_req_ni;
  end

  rst_sup_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NUM_SRC{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_act),
    .q_o   (sync_act)
  );

  rst_sup_hold_timer #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_active_i(sync_act),
    .asserted_o  (asserted),
    .busy_o      (hold_busy_o)
  );

  rst_sup_pol #(
    .ACTIVE_HIGH(ACTIVE_HIGH)
  ) u_pol (
    .asserted_i(asserted),
    .rst_o     (sys_rst_o)
  );

  assert_manual_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_act[int'(SRC_MANUAL)] && $past(sync_act[int'(SRC_MANUAL)])) |-> asserted);

  assert_busy_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_busy_o |-> (sync_act == '0));
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int H = 12;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_ok = 1'b1;
  logic mr_n = 1'b1;
  logic wd_n = 1'b1;
  logic rst_lo, rst_hi, busy_lo, busy_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;
  string cur_req = "R2";

  always #10 clk = ~clk;

  rst_supervisor #(.HOLD_CYCLES(H), .SYNC_STAGES(S), .ACTIVE_HIGH(1'b0)) u_rst_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup_ok), .man_rst_ni(mr_n),
    .wdog_req_ni(wd_n), .sys_rst_o(rst_lo), .hold_busy_o(busy_lo));

  rst_supervisor #(.HOLD_CYCLES(H), .SYNC_STAGES(S), .ACTIVE_HIGH(1'b1)) u_rst_supervisor_hi (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup_ok), .man_rst_ni(mr_n),
    .wdog_req_ni(wd_n), .sys_rst_o(rst_hi), .hold_busy_o(busy_hi));

  // reference model: delay line of raw activity, plus a run of quiet edges
  bit act_q[$];
  int quiet;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q = {};
      for (int i = 0; i < S; i++) act_q.push_back(1'b1);
      quiet = 0;
    end else begin
      bit raw;
      bit old;
      raw = !sup_ok || !mr_n || !wd_n;
      act_q.push_back(raw);
      old = act_q.pop_front();
      if (old) quiet = 0;
      else if (quiet < H) quiet++;
    end
  end

  function automatic bit exp_rst();
    return !rst_n || (quiet < H);
  endfunction

  function automatic bit exp_busy();
    return rst_n && (quiet < H) && !act_q[0];
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(cur_req, "sys_rst_o (active-low)", rst_lo, !exp_rst());
      chk("R6", "sys_rst_o (active-high)", rst_hi, exp_rst());
      chk("R8", "hold_busy_o", busy_lo, exp_busy());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int width;
    // R9: outputs asserted while power-on clear is low
    idle(3);
    chk("R9", "reset state active-low", rst_lo, 1'b0);
    chk("R9", "reset state active-high", rst_hi, 1'b1);
    chk("R8", "busy in reset", busy_lo, 1'b0);
    cmp_en = 1'b1;

    // R2: power-up hold
    cur_req = "R2";
    rst_n = 1'b1;
    idle(S + H + 6);
    chk("R2", "released after power-up", rst_lo, 1'b1);

    // R1/R5: manual held several cycles
    cur_req = "R5";
    mr_n = 1'b0;
    idle(8);
    chk("R1", "asserted while manual low", rst_lo, 1'b0);
    mr_n = 1'b1;
    idle(S + H + 5);

    // R3: single-cycle pulse gives exactly H cycles
    cur_req = "R3";
    mr_n = 1'b0;
    idle(1);
    mr_n = 1'b1;
    width = 0;
    for (int i = 0; i < H + 10; i++) begin
      @(negedge clk);
      if (rst_lo === 1'b0) width++;
    end
    chk("R3", "one-cycle pulse width is H", (width == H), 1'b1);
    if (width != H) $display("FAIL R3 width actual=%0d expected=%0d", width, H);

    // R4: supply dip mid-hold restarts the count
    cur_req = "R4";
    mr_n = 1'b0;
    idle(3);
    mr_n = 1'b1;
    idle(S + H / 2);
    chk("R4", "still holding before dip", rst_lo, 1'b0);
    sup_ok = 1'b0;
    idle(1);
    sup_ok = 1'b1;
    idle(S + H - 2);
    chk("R4", "hold restarted after dip", rst_lo, 1'b0);
    idle(8);
    chk("R4", "released after restart", rst_lo, 1'b1);

    // R1: long supply loss
    cur_req = "R1";
    sup_ok = 1'b0;
    idle(10);
    sup_ok = 1'b1;
    idle(S + H + 4);

    // R7: watchdog request like manual reset
    cur_req = "R7";
    wd_n = 1'b0;
    idle(4);
    chk("R7", "asserted on watchdog request", rst_lo, 1'b0);
    wd_n = 1'b1;
    idle(S + H + 4);
    chk("R7", "released after watchdog hold", rst_lo, 1'b1);

    // R9: power-on clear between edges asserts at once
    cur_req = "R9";
    @(posedge clk);
    #5;
    rst_n = 1'b0;
    #1;
    chk("R9", "async assert active-low", rst_lo, 1'b0);
    chk("R9", "async assert active-high", rst_hi, 1'b1);
    chk("R9", "busy cleared", busy_lo, 1'b0);
    idle(2);
    rst_n = 1'b1;
    cur_req = "R2";
    idle(S + H + 4);
    chk("R2", "released after second power-up", rst_lo, 1'b1);
    chk("R6", "high variant released", rst_hi, 1'b0);

    finish_run();
  end
endmodule